// File: doc/BRIEF.md
# Chained Descriptor Input Fetcher

This block reads message data out of memory and hands it, one 32-bit word per beat, to a hash core through a valid/ready stream. In chain mode it starts at a head pointer and fetches a four-word descriptor. It streams the bytes that descriptor points at, then moves to the next descriptor, and it keeps going until it finishes a descriptor whose terminal flag is set. In single-buffer mode it skips descriptors and streams one region given directly by an address and a byte count.

A one-cycle launch pulse starts a transfer. The configuration inputs are sampled on that cycle. The memory side is a plain request/response read port that allows one read in flight. When the last byte has been handed over, the block raises a one-cycle completion pulse, even if the core is still hashing that data. If a read returns an error, the block raises a one-cycle read-error pulse instead of the completion pulse and goes back to idle.

Top module: `llf_chain_reader`

## Requirements
- R1: After reset `busy`, `out_valid`, `mem_rd_en`, `src_done` and `rd_err` are all 0.
- R2: In chain mode a descriptor is read as four words at byte addresses A, A+4, A+8 and A+12, in that order. They hold the source byte address, the source byte length, the next-descriptor byte address and the flags. The first A is `cfg_head_addr`.
- R3: The data of a descriptor is read as consecutive words starting at its source address, which must be word aligned. Each word read appears unchanged on `out_data`, in address order.
- R4: `out_keep` bit i marks byte `out_data[8i+7:8i]` as valid. It is all ones on full beats. On the last beat of a region whose length is not a multiple of 4, only the low (length mod 4) bits are set.
- R5: If flags bit 31 is set, the block stops after that descriptor's data and never reads its next-descriptor address. If bit 31 is clear, the next descriptor is fetched from that address.
- R6: A region of length zero produces no data reads and no beats. This applies to a descriptor or to the single buffer.
- R7: With `cfg_chain_en` = 0, data is read from `cfg_buf_addr` for `cfg_buf_len` bytes and no descriptor is read.
- R8: `src_done` is a one-cycle pulse, issued exactly once per successful transfer, after the final beat has been accepted.
- R9: A cycle with `mem_rerr` = 1 while a read is pending ends the transfer. `rd_err` pulses once, `src_done` does not pulse, and no further reads or beats follow.
- R10: While `out_valid` = 1 and `out_ready` = 0, `out_valid`, `out_data` and `out_keep` hold their values.
- R11: A `launch` pulse while `busy` = 1 is ignored. This includes the cycle in which `src_done` or `rd_err` is high.
- R12: `mem_rd_en` is a one-cycle pulse, and no new read is issued while a previous read has not yet had its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch | input | 1 | Start pulse, taken only when idle |
| cfg_chain_en | input | 1 | 1: walk descriptors, 0: single buffer |
| cfg_head_addr | input | AW | Byte address of the first descriptor |
| cfg_buf_addr | input | AW | Byte address of the single buffer |
| cfg_buf_len | input | LW | Byte count of the single buffer |
| mem_rd_en | output | 1 | Read request pulse |
| mem_addr | output | AW | Byte address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| mem_rerr | input | 1 | Read response is an error |
| out_valid | output | 1 | Beat valid toward the hash core |
| out_data | output | DW | Beat data |
| out_keep | output | DW/8 | Valid byte lanes of the beat |
| out_ready | input | 1 | Hash core accepts the beat |
| busy | output | 1 | Transfer in progress |
| src_done | output | 1 | All input handed over |
| rd_err | output | 1 | Transfer aborted by a read error |

## Verification
Two functions can fall in the same cycle: the completion (or error) pulse, and a new launch request arriving while the engine is retiring. The bench provokes this by raising `launch` in the exact cycle where `src_done` is observed high, with configuration that would cause reads if it were accepted. It then judges, after several idle cycles, that no extra memory read occurred and that `busy` is low. Backpressure and memory latency are randomized at the same time. This makes beat acceptance land on every possible cycle relative to the next descriptor fetch, and the recorded read addresses and beats are compared against a model that walks the same memory image.

// File: rtl/llf_pkg.sv
package llf_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DREQ, ST_DWAIT, ST_DLOAD, ST_CHECK,
    ST_BREQ, ST_BWAIT, ST_HOLD, ST_FIN, ST_FAIL
  } llf_state_e;

  localparam int DESC_WORDS = 4;
  localparam int LAST_BIT   = 31;

  typedef struct packed {
    logic [31:0] flags;
    logic [31:0] next;
    logic [31:0] len;
    logic [31:0] src;
  } llf_desc_t;
endpackage

// File: rtl/llf_desc_capture.sv
module llf_desc_capture #(
  parameter int WORDS = 4,
  parameter int W     = 32,
  localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [IW-1:0]             idx,
  input  logic [W-1:0]              wdata,
  output logic [WORDS-1:0][W-1:0]   words_q
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        words_q[g] <= '0;
      else if (wr_en && idx == IW'(g))
        words_q[g] <= wdata;
    end
  end
endmodule

// File: rtl/llf_beat_out.sv
module llf_beat_out #(
  parameter int W  = 32,
  localparam int B = W / 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] ld_data,
  input  logic [B-1:0] ld_keep,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic [B-1:0] out_keep,
  output logic         accept
);
  assign accept = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_keep  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= ld_data;
      out_keep  <= ld_keep;
    end else if (accept) begin
      out_valid <= 1'b0;
    end
  end

  // R10
  hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_keep));

  // R4
  keep_shape_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_keep[0] && $onehot({1'b0, out_keep} + {{B{1'b0}}, 1'b1}));
endmodule

// File: rtl/llf_chain_reader.sv
module llf_chain_reader
  import llf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 32,
  localparam int BYTES = DW / 8,
  localparam int IW    = $clog2(DESC_WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             cfg_chain_en,
  input  logic [AW-1:0]    cfg_head_addr,
  input  logic [AW-1:0]    cfg_buf_addr,
  input  logic [LW-1:0]    cfg_buf_len,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_rerr,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  output logic [BYTES-1:0] out_keep,
  input  logic             out_ready,
  output logic             busy,
  output logic             src_done,
  output logic             rd_err
);
  llf_state_e st;
  logic [IW-1:0]  widx;
  logic [AW-1:0]  rd_addr, cur, nxt;
  logic [LW-1:0]  rem, take;
  logic           last;
  logic [DESC_WORDS-1:0][DW-1:0] dwords;
  llf_desc_t      desc;
  logic [BYTES-1:0] nkeep;
  logic           d_wr, b_load, accept;

  assign desc  = llf_desc_t'(dwords);
  assign d_wr  = (st == ST_DWAIT) && mem_rvalid && !mem_rerr;
  assign b_load = (st == ST_BWAIT) && mem_rvalid && !mem_rerr;
  assign take  = (rem >= LW'(BYTES)) ? LW'(BYTES) : rem;

  for (genvar b = 0; b < BYTES; b++) begin : g_keep
    assign nkeep[b] = rem > LW'(b);
  end

  llf_desc_capture #(.WORDS(DESC_WORDS), .W(DW)) u_cap (
    .clk(clk), .rst(rst), .wr_en(d_wr), .idx(widx),
    .wdata(mem_rdata), .words_q(dwords)
  );

  llf_beat_out #(.W(DW)) u_beat (
    .clk(clk), .rst(rst), .load(b_load), .ld_data(mem_rdata),
    .ld_keep(nkeep), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_keep(out_keep), .accept(accept)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      widx    <= '0;
      rd_addr <= '0;
      cur     <= '0;
      nxt     <= '0;
      rem     <= '0;
      last    <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (launch) begin
          if (cfg_chain_en) begin
            rd_addr <= cfg_head_addr;
            widx    <= '0;
            st      <= ST_DREQ;
          end else begin
            cur  <= cfg_buf_addr;
            rem  <= cfg_buf_len;
            last <= 1'b1;
            st   <= ST_CHECK;
          end
        end
        ST_DREQ: st <= ST_DWAIT;
        ST_DWAIT: begin
          if (mem_rerr) st <= ST_FAIL;
          else if (mem_rvalid) begin
            if (widx == IW'(DESC_WORDS - 1)) st <= ST_DLOAD;
            else begin
              widx    <= widx + 1'b1;
              rd_addr <= rd_addr + AW'(BYTES);
              st      <= ST_DREQ;
            end
          end
        end
        ST_DLOAD: begin
          cur  <= AW'(desc.src);
          rem  <= LW'(desc.len);
          nxt  <= AW'(desc.next);
          last <= desc.flags[LAST_BIT];
          st   <= ST_CHECK;
        end
        ST_CHECK: begin
          if (rem != '0) st <= ST_BREQ;
          else if (last) st <= ST_FIN;
          else begin
            rd_addr <= nxt;
            widx    <= '0;
            st      <= ST_DREQ;
          end
        end
        ST_BREQ: st <= ST_BWAIT;
        ST_BWAIT: begin
          if (mem_rerr) st <= ST_FAIL;
          else if (mem_rvalid) begin
            rem <= rem - take;
            cur <= cur + AW'(BYTES);
            st  <= ST_HOLD;
          end
        end
        ST_HOLD: if (accept) st <= ST_CHECK;
        ST_FIN:  st <= ST_IDLE;
        ST_FAIL: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd_en = (st == ST_DREQ) || (st == ST_BREQ);
  assign mem_addr  = (st == ST_BREQ) ? cur : rd_addr;
  assign busy      = (st != ST_IDLE);
  assign src_done  = (st == ST_FIN);
  assign rd_err    = (st == ST_FAIL);

  // R12
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    src_done |=> !src_done && !busy);
  // R9
  err_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> !src_done && !out_valid);
  // R9
  err_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rd_err |=> !busy && !mem_rd_en);
  // R11
  busy_launch_chk: assert property (@(posedge clk) disable iff (rst)
    busy && launch && !src_done && !rd_err |=> busy);
  // R12
  no_rd_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !mem_rd_en);
endmodule

// File: tb/llf_chain_reader_bench.sv
module llf_chain_reader_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, launch, cfg_chain_en;
  logic [31:0] cfg_head_addr, cfg_buf_addr, cfg_buf_len;
  logic mem_rd_en, mem_rvalid, mem_rerr;
  logic [31:0] mem_addr, mem_rdata;
  logic out_valid, out_ready, busy, src_done, rd_err;
  logic [31:0] out_data;
  logic [3:0] out_keep;

  llf_chain_reader u_llf_chain_reader (
    .clk(clk), .rst(rst), .launch(launch), .cfg_chain_en(cfg_chain_en),
    .cfg_head_addr(cfg_head_addr), .cfg_buf_addr(cfg_buf_addr),
    .cfg_buf_len(cfg_buf_len), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
    .out_valid(out_valid), .out_data(out_data), .out_keep(out_keep),
    .out_ready(out_ready), .busy(busy), .src_done(src_done), .rd_err(rd_err)
  );

  logic [31:0] mem [0:255];
  logic [31:0] exp_ra[$], got_ra[$], exp_d[$], got_d[$];
  logic [3:0]  exp_k[$], got_k[$];
  int tests = 0, fails = 0, n_done = 0, n_err = 0;
  bit err_on = 0, stop = 0;
  logic [31:0] err_addr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rdw(input logic [31:0] a);
    return mem[a[9:2]];
  endfunction

  task automatic push_rd(input logic [31:0] a, output bit ok);
    ok = 0;
    if (stop) return;
    exp_ra.push_back(a);
    if (err_on && a == err_addr) stop = 1;
    else ok = 1;
  endtask

  task automatic stream(input logic [31:0] src, input int len);
    bit ok;
    for (int off = 0; off < len; off += 4) begin
      logic [3:0] k;
      push_rd(src + off, ok);
      if (!ok) return;
      exp_d.push_back(rdw(src + off));
      for (int b = 0; b < 4; b++) k[b] = (len - off) > b;
      exp_k.push_back(k);
    end
  endtask

  task automatic build_expect(input bit chain, input logic [31:0] head,
                              input logic [31:0] baddr, input int blen);
    logic [31:0] a;
    logic [31:0] w [4];
    bit ok;
    exp_ra.delete(); exp_d.delete(); exp_k.delete(); stop = 0;
    if (!chain) begin
      stream(baddr, blen);
      return;
    end
    a = head;
    for (int n = 0; n < 16; n++) begin
      for (int k = 0; k < 4; k++) begin
        push_rd(a + 4 * k, ok);
        if (!ok) return;
        w[k] = rdw(a + 4 * k);
      end
      stream(w[0], int'(w[1]));
      if (stop || w[3][31]) return;
      a = w[2];
    end
  endtask

  // memory responder, stream sink, pulse counters
  initial begin
    bit pend = 0, prev_stall = 0;
    int cnt = 0;
    logic [31:0] paddr = '0, pd = '0;
    logic [3:0] pk = '0;
    mem_rvalid = 0; mem_rerr = 0; mem_rdata = '0; out_ready = 0;
    forever begin
      @(negedge clk);
      mem_rvalid = 0; mem_rerr = 0;
      if (rst) begin
        pend = 0; prev_stall = 0;
      end else begin
        if (pend) begin
          cnt--;
          if (cnt == 0) begin
            pend = 0;
            if (err_on && paddr == err_addr) mem_rerr = 1;
            else begin mem_rvalid = 1; mem_rdata = rdw(paddr); end
          end
        end
        if (mem_rd_en) begin
          // R12: one read in flight
          if (pend) chk(0, "R12", "read issued while pending", mem_addr, paddr);
          got_ra.push_back(mem_addr);
          pend = 1; paddr = mem_addr; cnt = 1 + int'($urandom % 3);
        end
        if (prev_stall)  // R10
          chk(out_valid && out_data == pd && out_keep == pk, "R10",
              "stalled beat changed", out_data, pd);
        out_ready = ($urandom % 4) != 0;
        if (out_valid && out_ready) begin
          got_d.push_back(out_data); got_k.push_back(out_keep);
        end
        prev_stall = out_valid && !out_ready;
        pd = out_data; pk = out_keep;
        if (src_done) n_done++;
        if (rd_err) n_err++;
      end
    end
  end

  task automatic run_case(input string req, input bit chain, input logic [31:0] head,
                          input logic [31:0] baddr, input int blen,
                          input bit relaunch, input bit poke);
    int cyc = 0;
    bit exp_fail;
    build_expect(chain, head, baddr, blen);
    exp_fail = stop;
    got_ra.delete(); got_d.delete(); got_k.delete();
    n_done = 0; n_err = 0;
    @(negedge clk);
    cfg_chain_en = chain; cfg_head_addr = head; cfg_buf_addr = baddr;
    cfg_buf_len = blen; launch = 1;
    @(negedge clk);
    launch = 0;
    while (cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3) begin launch = 1; cfg_chain_en = ~chain; end
      else if (poke && cyc == 4) begin launch = 0; cfg_chain_en = chain; end
      if (src_done || rd_err) begin
        if (relaunch) launch = 1;  // R11: lands in the retire cycle
        break;
      end
    end
    @(negedge clk);
    launch = 0;
    repeat (5) @(negedge clk);
    chk(got_ra.size() == exp_ra.size(), req, "read count", got_ra.size(), exp_ra.size());
    foreach (exp_ra[i]) if (i < got_ra.size() && got_ra[i] !== exp_ra[i]) begin
      chk(0, req, $sformatf("read addr #%0d", i), got_ra[i], exp_ra[i]); break;
    end
    chk(got_d.size() == exp_d.size(), req, "beat count", got_d.size(), exp_d.size());
    foreach (exp_d[i]) if (i < got_d.size() &&
                           (got_d[i] !== exp_d[i] || got_k[i] !== exp_k[i])) begin
      chk(0, req, $sformatf("beat #%0d data/keep", i), got_d[i], exp_d[i]); break;
    end
    chk(n_done == (exp_fail ? 0 : 1), "R8", "done pulses", n_done, exp_fail ? 0 : 1);
    chk(n_err == (exp_fail ? 1 : 0), "R9", "error pulses", n_err, exp_fail ? 1 : 0);
    chk(!busy, req, "busy after end", busy, 0);
  endtask

  task automatic fill_data();
    for (int i = 64; i < 256; i++) mem[i] = $urandom;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] s, input logic [31:0] l,
                          input logic [31:0] n, input logic [31:0] f);
    mem[a[9:2]] = s; mem[a[9:2] + 1] = l; mem[a[9:2] + 2] = n; mem[a[9:2] + 3] = f;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    rst = 1; launch = 0; cfg_chain_en = 0;
    cfg_head_addr = '0; cfg_buf_addr = '0; cfg_buf_len = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(!busy && !out_valid && !mem_rd_en && !src_done && !rd_err, "R1",
        "outputs after reset", {busy, out_valid, mem_rd_en, src_done, rd_err}, 0);
    fill_data();
    // R7 R4 R3: single buffer with 2-byte tail, plus relaunch in done cycle (R11)
    run_case("R7", 0, 32'h0, 32'h100, 10, 1, 0);
    // R6: empty single buffer
    run_case("R6", 0, 32'h0, 32'h180, 0, 0, 0);
    // R2 R5 R6: three descriptors, middle empty, terminal next points at junk
    put_desc(32'h40, 32'h200, 8, 32'h10, 32'h0000_0003);
    put_desc(32'h10, 32'h280, 0, 32'h20, 32'h0);
    put_desc(32'h20, 32'h300, 5, 32'h30, 32'h8000_0001);
    put_desc(32'h30, 32'h120, 16, 32'h0, 32'h8000_0000);
    run_case("R5", 1, 32'h40, 32'h0, 0, 1, 0);
    // R11: launch mid-transfer with the other mode selected
    run_case("R11", 1, 32'h40, 32'h0, 0, 0, 1);
    // R6: empty terminal descriptor first
    put_desc(32'h50, 32'h200, 0, 32'h40, 32'h8000_0000);
    run_case("R6", 1, 32'h50, 32'h0, 0, 0, 0);
    // R9: error on a data read, then on a descriptor read
    err_on = 1; err_addr = 32'h204;
    run_case("R9", 1, 32'h40, 32'h0, 0, 0, 0);
    err_addr = 32'h28;
    run_case("R9", 1, 32'h40, 32'h0, 0, 0, 0);
    err_on = 0;
    // R3 R4 R5: random chains
    for (int r = 0; r < 24; r++) begin
      int nd = 1 + int'($urandom % 4);
      fill_data();
      for (int i = 0; i < nd; i++) begin
        logic [31:0] a = 32'h10 + 32'h20 * (nd - 1 - i);
        logic [31:0] nx = (i == nd - 1) ? 32'h3F0 : 32'h10 + 32'h20 * (nd - 2 - i);
        logic [31:0] fl = {(i == nd - 1), 23'd0, 8'($urandom)};
        put_desc(a, 32'h100 + 4 * ($urandom % 96), $urandom % 33, nx, fl);
      end
      if (r % 4 == 3) begin
        build_expect(1, 32'h10 + 32'h20 * (nd - 1), 0, 0);
        err_addr = exp_ra[$urandom % exp_ra.size()];
        err_on = 1;
      end
      run_case("R3", 1, 32'h10 + 32'h20 * (nd - 1), 32'h0, 0, 0, 0);
      err_on = 0;
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule